// File: doc/BRIEF.md
# RGB Pixel Reducer and Packer

This block accepts a stream of 24-bit RGB pixels, one per accepted cycle, and turns each one into a 16-bit colour word. Two 16-bit words are combined into each 32-bit output word for a memory write stream. A format input selects one of two layouts. The first is 5:6:5, with five bits of red, six of green and five of blue. The second is 5:5:5 with a key bit, where each colour keeps five bits and the top bit carries a colour-key flag that arrives with the pixel.

The colour depth is reduced in one of two ways, chosen by a mode input. Plain truncation drops the low bits of each channel. Error-diffusion dither adds, per channel, the bits that the previous pixel of the same line lost, saturates at full scale, and only then truncates. A phase input, taken from bit 1 of the DMA base address, selects whether the first pixel of each line lands in the lower or the upper half of its word. Partial words are marked by a 4-bit byte-enable output. Both sides use a valid/ready handshake.

Top module: `rgb_pixel_packer`

## Requirements
- R1: Within a word, the earlier pixel occupies bits 15:0 and the later pixel occupies bits 31:16. After a pixel is placed in the lower half, the next pixel of the same line goes into the upper half and completes the word.
- R2: With cfg_fmt = 0 (5:6:5), each 16-bit word holds red in bits 15:11, green in bits 10:5 and blue in bits 4:0. Red is in_rgb[23:16], green is in_rgb[15:8] and blue is in_rgb[7:0].
- R3: With cfg_fmt = 1 (5:5:5 with key), bit 15 is in_key, red is in bits 14:10, green in bits 9:5 and blue in bits 4:0.
- R4: With cfg_dither = 0, each kept field equals the top bits of its 8-bit channel, and the dropped bits are discarded.
- R5: With cfg_dither = 1, each channel adds the remainder left by the previous pixel of the line and clamps the sum at 255. It then keeps the top bits and carries the low bits of the clamped value to the next pixel.
- R6: A pixel flagged in_sol uses a carried remainder of zero.
- R7: With cfg_phase = 1, a line's first pixel goes into bits 31:16 of a word that is emitted at once, with out_be = 4'b1100 and bits 15:0 zero.
- R8: A pixel flagged in_eol that lands in the lower half is emitted at once, with out_be = 4'b0011 and bits 31:16 zero.
- R9: A word holding two pixels carries out_be = 4'b1111. Every emitted word has one of the three byte-enable values 0011, 1100 or 1111.
- R10: While out_valid is high and out_ready is low, out_data and out_be hold steady and in_ready is low.
- R11: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fmt | input | 1 | 0 = 5:6:5, 1 = 5:5:5 with key bit |
| cfg_dither | input | 1 | 0 = truncate, 1 = error-diffusion dither |
| cfg_phase | input | 1 | DMA base address bit 1; 1 starts lines in the upper half |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel taken when high together with in_valid |
| in_rgb | input | 24 | Red 23:16, green 15:8, blue 7:0 |
| in_key | input | 1 | Colour-key flag for the 5:5:5 layout |
| in_sol | input | 1 | First pixel of a line |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink accepts the word |
| out_data | output | 32 | Packed pair of 16-bit pixels |
| out_be | output | 4 | Byte enables of out_data |

## Verification
Random lines of odd and even length are run first with truncation, in both layouts and both phases. Odd lengths force the end-of-line flush, and the upper-half phase separates the 1100 and 1111 word shapes. Dithered lines are then run with random pixels and with runs of near-white pixels. Random pixels show whether the remainder carries along the line and is cleared at each line start. Near-white runs show whether the clamp at full scale works, because an unclamped sum would wrap to a dark value. A random stall pattern on out_ready then shows whether a waiting word holds steady and whether input is held off while it waits.

// File: rtl/pxpk_pkg.sv
// Shared types and constants for the RGB pixel packer.
package pxpk_pkg;
    // Output pixel layout selector.
    typedef enum logic {
        FMT_565  = 1'b0,
        FMT_555K = 1'b1
    } pix_fmt_e;

    localparam int CHAN_W  = 8;
    localparam int HALF_W  = 16;
    localparam int WORD_W  = 2 * HALF_W;
    localparam int BE_W    = WORD_W / 8;
    localparam int DROP_W  = $clog2(CHAN_W);

    localparam logic [BE_W-1:0] BE_LOW  = 4'b0011;
    localparam logic [BE_W-1:0] BE_HIGH = 4'b1100;
    localparam logic [BE_W-1:0] BE_ALL  = 4'b1111;
endpackage

// File: rtl/pxpk_chan_reduce.sv
// One colour channel: reduces an 8-bit value by DROP low bits using either
// truncation or error diffusion along the line. Assumes drop <= MAXDROP and
// that 'step' pulses once for each accepted pixel.
module pxpk_chan_reduce #(
    parameter int CW      = 8,
    parameter int OUTW    = 5,
    parameter int MAXDROP = 3,
    localparam int DW     = $clog2(CW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            line_start,
    input  logic            dither_en,
    input  logic [DW-1:0]   drop,
    input  logic [CW-1:0]   chan_in,
    output logic [OUTW-1:0] chan_out
);
    localparam int ERR_LIM = 1 << MAXDROP;

    logic [CW-1:0] err_q;
    logic [CW-1:0] carry_in;
    logic [CW:0]   sum;
    logic [CW-1:0] clamped;
    logic [CW-1:0] low_mask;
    logic [CW-1:0] picked;

    // Adds the carried remainder and clamps at full scale before the shift.
    always_comb begin
        carry_in = line_start ? '0 : err_q;
        sum      = {1'b0, chan_in} + {1'b0, carry_in};
        clamped  = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
        low_mask = ~({CW{1'b1}} << drop);
        picked   = dither_en ? clamped : chan_in;
        chan_out = OUTW'(picked >> drop);
    end

    // Keeps the remainder lost by this pixel for the next pixel of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (step) begin
            err_q <= dither_en ? (clamped & low_mask) : '0;
        end
    end

    // R5: the remainder never reaches one step of the kept field.
    a_r5_err_bound: assert property (@(posedge clk) disable iff (!rst_n)
        err_q < CW'(ERR_LIM));
endmodule

// File: rtl/pxpk_format.sv
// Places reduced channels and the key flag into one 16-bit pixel word.
// Assumes red and blue are already five bits and green six bits wide.
module pxpk_format
    import pxpk_pkg::*;
(
    input  pix_fmt_e          fmt,
    input  logic [4:0]        red,
    input  logic [5:0]        grn,
    input  logic [4:0]        blu,
    input  logic              key,
    output logic [HALF_W-1:0] pix
);
    // Chooses the field layout for the selected format.
    always_comb begin
        if (fmt == FMT_565) pix = {red, grn, blu};
        else                pix = {key, red, grn[4:0], blu};
    end
endmodule

// File: rtl/pxpk_pack.sv
// Packs 16-bit pixels in pairs into 32-bit words with byte enables.
// Assumes in_eol marks each line's last pixel; a line start discards any
// unpaired half left over from a line without an end marker.
module pxpk_pack
    import pxpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_hi,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HALF_W-1:0] in_pix,
    input  logic              in_sol,
    input  logic              in_eol,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [BE_W-1:0]   out_be
);
    logic              upper_next;
    logic              half_full;
    logic [HALF_W-1:0] low_q;
    logic              take;
    logic              go_upper;
    logic              have_low;

    // Input is held off only while a finished word waits at the output.
    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    // Picks the half for this pixel and whether a lower half is pending.
    always_comb begin
        go_upper = in_sol ? phase_hi : upper_next;
        have_low = half_full && !in_sol;
    end

    // Fills halves and launches a word when it is complete or the line ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_next <= 1'b0;
            half_full  <= 1'b0;
            low_q      <= '0;
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_be     <= '0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (take) begin
                if (!go_upper) begin
                    low_q <= in_pix;
                    if (in_eol) begin
                        out_valid  <= 1'b1;
                        out_data   <= {{HALF_W{1'b0}}, in_pix};
                        out_be     <= BE_LOW;
                        half_full  <= 1'b0;
                        upper_next <= 1'b0;
                    end else begin
                        half_full  <= 1'b1;
                        upper_next <= 1'b1;
                    end
                end else begin
                    out_valid  <= 1'b1;
                    out_data   <= {in_pix, have_low ? low_q : {HALF_W{1'b0}}};
                    out_be     <= have_low ? BE_ALL : BE_HIGH;
                    half_full  <= 1'b0;
                    upper_next <= 1'b0;
                end
            end
        end
    end

    // R10: a stalled word stays put.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_be));
    // R9: only three byte-enable shapes exist.
    a_r9_be_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_be == BE_LOW || out_be == BE_HIGH || out_be == BE_ALL));
    // R8: a flushed word has an empty upper half.
    a_r8_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_be == BE_LOW |-> out_data[WORD_W-1:HALF_W] == '0);
    // R7: an upper-only word has an empty lower half.
    a_r7_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_be == BE_HIGH |-> out_data[HALF_W-1:0] == '0);
    // R1: a pending lower half always expects its upper partner next.
    a_r1_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        half_full |-> upper_next);
endmodule

// File: rtl/rgb_pixel_packer.sv
// Top: reduces 24-bit RGB pixels to 16 bits (5:6:5 or 5:5:5 plus key) by
// truncation or dither, and packs pixel pairs into 32-bit words.
// Assumes cfg_* inputs change only between lines.
module rgb_pixel_packer
    import pxpk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_fmt,
    input  logic        cfg_dither,
    input  logic        cfg_phase,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [23:0] in_rgb,
    input  logic        in_key,
    input  logic        in_sol,
    input  logic        in_eol,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic [3:0]  out_be
);
    pix_fmt_e          fmt;
    logic              step;
    logic [DROP_W-1:0] grn_drop;
    logic [4:0]        red5;
    logic [5:0]        grn6;
    logic [4:0]        blu5;
    logic [HALF_W-1:0] pix16;

    assign fmt      = pix_fmt_e'(cfg_fmt);
    assign step     = in_valid && in_ready;
    assign grn_drop = (fmt == FMT_565) ? DROP_W'(2) : DROP_W'(3);

    pxpk_chan_reduce #(.CW(CHAN_W), .OUTW(5), .MAXDROP(3)) u_red (
        .clk(clk), .rst_n(rst_n), .step(step), .line_start(in_sol),
        .dither_en(cfg_dither), .drop(DROP_W'(3)),
        .chan_in(in_rgb[23:16]), .chan_out(red5));

    pxpk_chan_reduce #(.CW(CHAN_W), .OUTW(6), .MAXDROP(3)) u_grn (
        .clk(clk), .rst_n(rst_n), .step(step), .line_start(in_sol),
        .dither_en(cfg_dither), .drop(grn_drop),
        .chan_in(in_rgb[15:8]), .chan_out(grn6));

    pxpk_chan_reduce #(.CW(CHAN_W), .OUTW(5), .MAXDROP(3)) u_blu (
        .clk(clk), .rst_n(rst_n), .step(step), .line_start(in_sol),
        .dither_en(cfg_dither), .drop(DROP_W'(3)),
        .chan_in(in_rgb[7:0]), .chan_out(blu5));

    pxpk_format u_fmt (
        .fmt(fmt), .red(red5), .grn(grn6), .blu(blu5), .key(in_key), .pix(pix16));

    pxpk_pack u_pack (
        .clk(clk), .rst_n(rst_n), .phase_hi(cfg_phase),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(pix16),
        .in_sol(in_sol), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_be(out_be));
endmodule

// File: tb/tb_rgb_pixel_packer.sv
module tb_rgb_pixel_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fmt = 1'b0, cfg_dither = 1'b0, cfg_phase = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_rgb = '0;
    logic        in_key = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [3:0]  out_be;

    int checks = 0;
    int errors = 0;
    int stall_pct = 0;
    string tag = "R11";

    logic [35:0] expq[$];
    logic [7:0]  m_err[3];
    bit          m_upper, m_half;
    logic [15:0] m_low;
    bit          prev_stall = 0;
    logic [35:0] prev_word;

    always #5 clk = ~clk;

    rgb_pixel_packer dut (.*);

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bench model of one channel: {next remainder, kept value}.
    function automatic logic [15:0] chan_model(logic [7:0] v, logic [7:0] e, int drop, bit dit);
        int s;
        s = int'(v) + int'(e);
        if (s > 255) s = 255;
        if (dit) return {8'(s % (1 << drop)), 8'(s >> drop)};
        return {8'h00, 8'(v >> drop)};
    endfunction

    task automatic model_accept();
        logic [15:0] r, g, b, p;
        bit up;
        if (in_sol) begin m_err[0] = 0; m_err[1] = 0; m_err[2] = 0; m_half = 0; end
        r = chan_model(in_rgb[23:16], m_err[2], 3, cfg_dither);
        g = chan_model(in_rgb[15:8],  m_err[1], cfg_fmt ? 3 : 2, cfg_dither);
        b = chan_model(in_rgb[7:0],   m_err[0], 3, cfg_dither);
        m_err[2] = r[15:8]; m_err[1] = g[15:8]; m_err[0] = b[15:8];
        if (!cfg_fmt) p = {r[4:0], g[5:0], b[4:0]};
        else          p = {in_key, r[4:0], g[4:0], b[4:0]};
        up = in_sol ? cfg_phase : m_upper;
        if (!up) begin
            m_low = p;
            if (in_eol) begin
                expq.push_back({4'b0011, 16'h0, p});
                m_half = 0; m_upper = 0;
            end else begin
                m_half = 1; m_upper = 1;
            end
        end else begin
            expq.push_back(m_half ? {4'b1111, p, m_low} : {4'b1100, p, 16'h0});
            m_half = 0; m_upper = 0;
        end
    endtask

    // One cycle: set out_ready at the falling edge, observe, then pass the rising edge.
    task automatic step(output bit took);
        logic [35:0] e;
        @(negedge clk);
        out_ready = ($urandom % 100) >= stall_pct;
        #1;
        if (prev_stall) begin
            check(out_valid && {out_be, out_data} == prev_word, "R10 hold",
                  {out_be, out_data}, prev_word);
        end
        prev_stall = out_valid && !out_ready;
        prev_word  = {out_be, out_data};
        if (prev_stall) check(!in_ready, "R10 in_ready low", 36'(in_ready), 36'h0);
        if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
                check(0, tag, {out_be, out_data}, 36'h0);
            end else begin
                e = expq.pop_front();
                check({out_be, out_data} == e, tag, {out_be, out_data}, e);
            end
        end
        took = in_valid && in_ready;
        if (took) model_accept();
        @(posedge clk);
        #1;
    endtask

    task automatic push_pixel(logic [23:0] rgb, bit key, bit sol, bit eol);
        bit took;
        in_valid = 1; in_rgb = rgb; in_key = key; in_sol = sol; in_eol = eol;
        do step(took); while (!took);
        in_valid = 0;
        if (($urandom % 4) == 0) step(took);
    endtask

    task automatic send_line(int len, bit bright);
        logic [23:0] v;
        for (int i = 0; i < len; i++) begin
            v = $urandom;
            if (bright) v = v | 24'hF8F8F8;
            push_pixel(v, $urandom % 2, i == 0, i == len - 1);
        end
    endtask

    task automatic drain();
        bit took;
        int n = 0;
        int keep = stall_pct;
        stall_pct = 0;
        while (expq.size() != 0 && n < 100) begin step(took); n++; end
        check(expq.size() == 0, {tag, " drain"}, 36'(expq.size()), 36'h0);
        stall_pct = keep;
    endtask

    task automatic run_lines(int count, bit bright);
        for (int k = 0; k < count; k++) send_line(1 + ($urandom % 9), bright);
        drain();
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        m_upper = 0; m_half = 0; m_low = 0;
        m_err[0] = 0; m_err[1] = 0; m_err[2] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid, "R11 out_valid after reset", 36'(out_valid), 36'h0);
        check(in_ready, "R11 in_ready after reset", 36'(in_ready), 36'h1);
        rst_n = 1;
        @(posedge clk); #1;

        // R2 R4: directed single-pixel line, 5:6:5 truncation, flushed low (R8).
        tag = "R2 R4 R8 directed";
        push_pixel(24'hF8FCF8, 0, 1, 1);
        push_pixel(24'h80_40_07, 0, 1, 1);
        drain();
        // R1 R9: directed two-pixel line.
        tag = "R1 R9 directed";
        push_pixel(24'h000000, 0, 1, 0);
        push_pixel(24'hFFFFFF, 0, 0, 1);
        drain();

        tag = "R1 R2 R4 R8 R9 random 565 truncate";
        run_lines(40, 0);

        tag = "R3 random 555 key truncate";
        cfg_fmt = 1;
        run_lines(40, 0);

        tag = "R7 upper phase";
        cfg_phase = 1;
        push_pixel(24'h123456, 1, 1, 1);
        run_lines(40, 0);

        tag = "R5 R6 dither 565";
        cfg_fmt = 0; cfg_phase = 0; cfg_dither = 1;
        run_lines(40, 0);

        tag = "R5 dither saturation near white";
        run_lines(20, 1);
        cfg_fmt = 1;
        run_lines(20, 1);

        tag = "R10 R5 R6 dither with stalls";
        stall_pct = 40;
        cfg_phase = 1;
        run_lines(40, 0);
        cfg_phase = 0; cfg_fmt = 0;
        run_lines(40, 0);
        stall_pct = 0;
        drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule